// File: doc/BRIEF.md
# SD Card Clock Divider and Wait Timeout

This block derives the SD card clock from the core clock. The divisor register holds the division ratio minus two, so a stored value V gives an SD clock period of V+2 core cycles. In data mode the block normally uses only the low three bits of that value, which allows fast transfers without reprogramming. Identification mode always uses the full value. A slow-card override keeps the full value in data mode as well. The switch between modes follows the `dataMode` input without any software action.

Besides the clock, the block provides a one-cycle enable strobe that marks the start of each SD clock period. It also holds a 32-bit wait timeout. When `waitActive` rises, the counter loads a programmed start value. It then counts down once per SD clock period while the wait continues. When the count reaches zero, the block emits a one-cycle `timeoutPulse`.

Top module: `sd_clk_divider`

## Requirements
- R1: In identification mode, a stored divisor V gives an SD clock period of N = V+2 core cycles. The high phase lasts ceil(N/2) cycles and the low phase lasts floor(N/2) cycles. V=0 gives 1 high and 1 low; V=0x7FF gives 1025 high and 1024 low.
- R2: In data mode with the slow-card flag clear, only divisor bits [2:0] set the period. Example: V=13 gives N=7, and V=8 gives N=2.
- R3: With the slow-card flag set, data mode uses the full 11-bit divisor. Example: V=13 gives N=15.
- R4: A divisor change never shortens or stretches the running period. The new period starts at the next SD clock rising edge.
- R5: `clkEn` is high for exactly one core cycle per SD clock period: the first cycle of the high phase.
- R6: A rise of `waitActive` loads the counter from the start value, even if a previous wait was cut short. `timeoutPulse` is high for one cycle, in the cycle after the core cycle that carries the start-value-th `clkEn` of the wait.
- R7: While `waitActive` is low, the counter holds and no pulse is issued. A start value of zero never produces a pulse.
- R8: After reset, `sdClk`, `clkEn` and `timeoutPulse` are low. The divisor, slow-card flag and start value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| divWrEn | input | 1 | Write strobe for the divisor register |
| divWrData | input | 11 | Divisor value (ratio minus two) |
| cfgWrEn | input | 1 | Write strobe for the slow-card flag |
| slowCardWr | input | 1 | New slow-card flag value |
| toutWrEn | input | 1 | Write strobe for the timeout start value |
| toutWrData | input | 32 | Timeout start value, in SD clock periods |
| dataMode | input | 1 | 1 = data mode, 0 = identification mode |
| waitActive | input | 1 | High while waiting on the card |
| sdClk | output | 1 | Divided SD clock |
| clkEn | output | 1 | One-cycle strobe at each SD clock rising edge |
| timeoutPulse | output | 1 | One-cycle pulse when the wait count expires |

## Verification
A wrong phase counter or period latch shows up at the ports within one SD clock period, as a high or low phase of the wrong length. Measuring both phase lengths after each divisor and mode setting therefore exposes it. A divisor taken in mid-period shows up as a shortened high phase in the period that contains the write. A wrong timeout count shows up at the pulse: the number of `clkEn` strobes counted between the start of the wait and `timeoutPulse` differs from the start value. Waits that are interrupted or have a zero start value expose a counter that fails to hold or fails to reload.

// File: rtl/sd_clkdiv_pkg.sv
package sd_clkdiv_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic periodWrap; // last core cycle of the current SD period
    logic toLoad;     // new wait begins: reload timeout counter
    logic toStep;     // decrement timeout counter
  } ctlStrb_t;
endpackage

// File: rtl/sdclk_datapath.sv
module sdclk_datapath
  import sd_clkdiv_pkg::*;
#(
  parameter int DIV_W      = 11,
  parameter int DATA_DIV_W = 3,
  parameter int TO_W       = 32,
  localparam int NW        = DIV_W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrb_t        strb,
  input  logic            divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic            cfgWrEn,
  input  logic            slowCardWr,
  input  logic            toutWrEn,
  input  logic [TO_W-1:0] toutWrData,
  input  logic            dataMode,
  output logic [NW-1:0]   curN,
  output logic [NW-1:0]   nextN,
  output logic            toAtOne,
  output logic            toIsZero
);
  logic [DIV_W-1:0] divReg;
  logic             slowReg;
  logic [TO_W-1:0]  startReg;
  logic [TO_W-1:0]  toCnt;
  logic [DIV_W-1:0] effDiv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg   <= '0;
      slowReg  <= 1'b0;
      startReg <= '0;
    end else begin
      if (divWrEn)  divReg   <= divWrData;
      if (cfgWrEn)  slowReg  <= slowCardWr;
      if (toutWrEn) startReg <= toutWrData;
    end
  end

  // Data mode narrows the divisor unless the slow-card flag is set
  always_comb begin
    if (dataMode && !slowReg)
      effDiv = {{(DIV_W-DATA_DIV_W){1'b0}}, divReg[DATA_DIV_W-1:0]};
    else
      effDiv = divReg;
  end

  assign nextN = {1'b0, effDiv} + NW'(2);

  // Period length latched only at a period boundary
  always_ff @(posedge clk) begin
    if (!rstN)                curN <= NW'(2);
    else if (strb.periodWrap) curN <= nextN;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           toCnt <= '0;
    else if (strb.toLoad) toCnt <= startReg;
    else if (strb.toStep) toCnt <= toCnt - TO_W'(1);
  end

  assign toAtOne  = (toCnt == TO_W'(1));
  assign toIsZero = (toCnt == '0);
endmodule

// File: rtl/sdclk_control.sv
module sdclk_control
  import sd_clkdiv_pkg::*;
#(
  parameter int DIV_W = 11,
  localparam int NW   = DIV_W + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NW-1:0] curN,
  input  logic [NW-1:0] nextN,
  input  logic          toAtOne,
  input  logic          toIsZero,
  input  logic          waitActive,
  output ctlStrb_t      strb,
  output logic          sdClk,
  output logic          clkEn,
  output logic          timeoutPulse
);
  logic [NW-1:0] phase;
  logic [NW-1:0] nextPhase;
  logic [NW-1:0] nextCurN;
  logic [NW:0]   hiLen;
  logic          wrap;
  logic          waitPrev;

  assign wrap      = (phase == curN - NW'(1));
  assign nextPhase = wrap ? '0 : phase + NW'(1);
  assign nextCurN  = wrap ? nextN : curN;
  assign hiLen     = ({1'b0, nextCurN} + (NW+1)'(1)) >> 1;

  assign strb.periodWrap = wrap;
  assign strb.toLoad     = waitActive && !waitPrev;
  assign strb.toStep     = waitActive && waitPrev && clkEn && !toIsZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase        <= NW'(1); // last cycle of a two-cycle period
      sdClk        <= 1'b0;
      clkEn        <= 1'b0;
      waitPrev     <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      phase        <= nextPhase;
      sdClk        <= ({1'b0, nextPhase} < hiLen);
      clkEn        <= wrap;
      waitPrev     <= waitActive;
      timeoutPulse <= strb.toStep && toAtOne;
    end
  end
endmodule

// File: rtl/sd_clk_divider.sv
module sd_clk_divider
  import sd_clkdiv_pkg::*;
#(
  parameter int DIV_W      = 11,
  parameter int DATA_DIV_W = 3,
  parameter int TO_W       = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             cfgWrEn,
  input  logic             slowCardWr,
  input  logic             toutWrEn,
  input  logic [TO_W-1:0]  toutWrData,
  input  logic             dataMode,
  input  logic             waitActive,
  output logic             sdClk,
  output logic             clkEn,
  output logic             timeoutPulse
);
  localparam int NW = DIV_W + 1;

  ctlStrb_t      strb;
  logic [NW-1:0] curN;
  logic [NW-1:0] nextN;
  logic          toAtOne;
  logic          toIsZero;

  sdclk_datapath #(.DIV_W(DIV_W), .DATA_DIV_W(DATA_DIV_W), .TO_W(TO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .divWrEn(divWrEn), .divWrData(divWrData),
    .cfgWrEn(cfgWrEn), .slowCardWr(slowCardWr),
    .toutWrEn(toutWrEn), .toutWrData(toutWrData),
    .dataMode(dataMode),
    .curN(curN), .nextN(nextN), .toAtOne(toAtOne), .toIsZero(toIsZero)
  );

  sdclk_control #(.DIV_W(DIV_W)) u_ctl (
    .clk(clk), .rstN(rstN), .curN(curN), .nextN(nextN),
    .toAtOne(toAtOne), .toIsZero(toIsZero), .waitActive(waitActive),
    .strb(strb), .sdClk(sdClk), .clkEn(clkEn), .timeoutPulse(timeoutPulse)
  );
endmodule

// File: rtl/sdclk_checker.sv
module sdclk_checker (
  input logic clk,
  input logic rstN,
  input logic sdClk,
  input logic clkEn,
  input logic timeoutPulse,
  input logic waitActive
);
  // R5: strobe only in a high cycle of the SD clock
  assert_en_in_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> sdClk);
  // R5: every rising edge of the SD clock carries the strobe
  assert_rise_has_en_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdClk) |-> clkEn);
  // R1: a period is at least two cycles, so strobes never touch
  assert_en_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |=> !clkEn);
  // R6: the timeout pulse lasts one cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);
  // R7: a pulse needs a wait that was active in the cycle before
  assert_pulse_needs_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> $past(waitActive));
endmodule

bind sd_clk_divider sdclk_checker u_chk (
  .clk(clk), .rstN(rstN), .sdClk(sdClk), .clkEn(clkEn),
  .timeoutPulse(timeoutPulse), .waitActive(waitActive)
);

// File: tb/test_sd_clk_divider.sv
module test_sd_clk_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        divWrEn = 1'b0;
  logic [10:0] divWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic        slowCardWr = 1'b0;
  logic        toutWrEn = 1'b0;
  logic [31:0] toutWrData = '0;
  logic        dataMode = 1'b0;
  logic        waitActive = 1'b0;
  logic        sdClk, clkEn, timeoutPulse;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  sd_clk_divider i_sd_clk_divider (
    .clk(clk), .rstN(rstN), .divWrEn(divWrEn), .divWrData(divWrData),
    .cfgWrEn(cfgWrEn), .slowCardWr(slowCardWr), .toutWrEn(toutWrEn),
    .toutWrData(toutWrData), .dataMode(dataMode), .waitActive(waitActive),
    .sdClk(sdClk), .clkEn(clkEn), .timeoutPulse(timeoutPulse)
  );

  // {divisor[10:0], slow, dataMode, expHigh[11:0], expLow[11:0]}
  localparam logic [36:0] VEC [0:9] = '{
    {11'd0,    1'b0, 1'b0, 12'd1,    12'd1},    // R1
    {11'd1,    1'b0, 1'b0, 12'd2,    12'd1},    // R1
    {11'd5,    1'b0, 1'b0, 12'd4,    12'd3},    // R1
    {11'd13,   1'b0, 1'b0, 12'd8,    12'd7},    // R1
    {11'd13,   1'b0, 1'b1, 12'd4,    12'd3},    // R2
    {11'd13,   1'b1, 1'b1, 12'd8,    12'd7},    // R3
    {11'd8,    1'b0, 1'b1, 12'd1,    12'd1},    // R2
    {11'h7FF,  1'b0, 1'b0, 12'd1025, 12'd1024}, // R1
    {11'h7FF,  1'b0, 1'b1, 12'd5,    12'd4},    // R2
    {11'h7FF,  1'b1, 1'b1, 12'd1025, 12'd1024}  // R3
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  task automatic wrDiv(input logic [10:0] v);
    @(negedge clk); divWrData = v; divWrEn = 1'b1;
    @(negedge clk); divWrEn = 1'b0;
  endtask

  task automatic wrCfg(input logic s);
    @(negedge clk); slowCardWr = s; cfgWrEn = 1'b1;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic wrStart(input logic [31:0] v);
    @(negedge clk); toutWrData = v; toutWrEn = 1'b1;
    @(negedge clk); toutWrEn = 1'b0;
  endtask

  // Measure one full period, starting at a strobe cycle
  task automatic measure(output int hi, output int lo);
    while (!clkEn) @(negedge clk);
    hi = 0; lo = 0;
    while (sdClk) begin hi++; @(negedge clk); end
    while (!sdClk) begin lo++; @(negedge clk); end
  endtask

  // Count strobes from the start of a wait until the pulse
  task automatic runWait(output int ens, output int width);
    @(negedge clk); waitActive = 1'b1;
    ens = 0;
    @(negedge clk);
    while (!timeoutPulse) begin
      if (clkEn) ens++;
      @(negedge clk);
    end
    width = 0;
    while (timeoutPulse) begin width++; @(negedge clk); end
    waitActive = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    int hi, lo, ens, wid, pulses;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 sdClk in reset", sdClk, 0);
    check("R8 clkEn in reset", clkEn, 0);
    check("R8 pulse in reset", timeoutPulse, 0);
    rstN = 1'b1;
    measure(hi, lo);
    check("R8 default divisor high", hi, 1);
    check("R8 default divisor low", lo, 1);
    // R8/R7: default start value zero gives no pulse
    @(negedge clk); waitActive = 1'b1;
    pulses = 0;
    repeat (30) begin @(negedge clk); if (timeoutPulse) pulses++; end
    waitActive = 1'b0;
    check("R8 zero start no pulse", pulses, 0);

    // Vector table: R1, R2, R3
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); dataMode = VEC[i][24];
      wrCfg(VEC[i][25]);
      wrDiv(VEC[i][36:26]);
      measure(hi, lo);
      measure(hi, lo);
      check($sformatf("R1/R2/R3 vec%0d high", i), hi, int'(VEC[i][23:12]));
      check($sformatf("R1/R2/R3 vec%0d low", i), lo, int'(VEC[i][11:0]));
    end

    // R5: exactly one strobe per period
    @(negedge clk); dataMode = 1'b0; wrCfg(1'b0); wrDiv(11'd4);
    measure(hi, lo);
    while (!clkEn) @(negedge clk);
    ens = 0;
    repeat (60) begin if (clkEn) ens++; @(negedge clk); end
    check("R5 strobes in 60 cycles of N=6", ens, 10);

    // R4: divisor written mid high phase; running period completes
    wrDiv(11'd20);
    measure(hi, lo);
    while (!clkEn) @(negedge clk);
    begin
      int k;
      k = 0; hi = 0; lo = 0;
      while (1) begin
        if (k == 3) begin divWrData = 11'd0; divWrEn = 1'b1; end
        else divWrEn = 1'b0;
        if (sdClk) begin
          if (lo != 0) break;
          hi++;
        end else lo++;
        k++;
        @(negedge clk);
      end
      divWrEn = 1'b0;
    end
    check("R4 running period high", hi, 11);
    check("R4 running period low", lo, 11);
    measure(hi, lo);
    check("R4 new period high", hi, 1);
    check("R4 new period low", lo, 1);

    // R6: timeout counts start value periods
    wrStart(32'd5);
    runWait(ens, wid);
    check("R6 strobes before pulse N=2", ens, 5);
    check("R6 pulse width", wid, 1);
    wrDiv(11'd2);
    wrStart(32'd3);
    runWait(ens, wid);
    check("R6 strobes before pulse N=4", ens, 3);

    // R7: interrupted wait holds, then R6 reload on next rise
    @(negedge clk); waitActive = 1'b1;
    ens = 0;
    @(negedge clk);
    while (ens < 2) begin
      if (clkEn) ens++;
      if (ens < 2) @(negedge clk);
    end
    waitActive = 1'b0;
    pulses = 0;
    repeat (40) begin @(negedge clk); if (timeoutPulse) pulses++; end
    check("R7 no pulse while idle", pulses, 0);
    runWait(ens, wid);
    check("R6 reload after interrupted wait", ens, 3);

    // R7: explicit zero start value
    wrStart(32'd0);
    @(negedge clk); waitActive = 1'b1;
    pulses = 0;
    repeat (40) begin @(negedge clk); if (timeoutPulse) pulses++; end
    waitActive = 1'b0;
    check("R7 zero start no pulse", pulses, 0);

    summary();
  end
endmodule